// File: doc/BRIEF.md
# Card Clock Source Selector and Divider

This block drives the clock contact of a smart card and an auxiliary clock towards the host. Everything runs in the crystal clock domain. The card clock can come from one of four sources. The first is the crystal divided by a slow ratio, and the second is the crystal divided by a fast ratio. The third is half the internal oscillator, which reaches the block as a one-cycle tick, and the fourth is a registered copy of an external strobe input. The card clock can also be parked low. A sleep input overrides all of these: it parks the card clock low and moves the auxiliary output to the internal-oscillator divider.

The source request comes from a strobe-select bit and a two-bit divide code. Both are captured only on an activation-start pulse, so a later wiggle on those pins does nothing. A change of source or ratio is applied only while the card clock is low. The new source starts from the beginning of its low phase, so no pulse is ever shortened. A sequencer enable gates the card clock. When the enable drops, a high phase already in progress runs to its natural end, and the clock then stays low.

The auxiliary clock is given as two signals. `aux_pass` tells the pad mux to pass the crystal clock through. `aux_div` is a level that toggles on every oscillator tick, and the mux uses it when `aux_pass` is low.

Top module: `card_clk_sel`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `card_clk` and `aux_div` are 0 and `aux_pass` is 1. The captured request after reset is strobe-select 0 with code 11.
- R2: Code 00 with strobe-select 0 makes `card_clk` the crystal divided by SLOW_DIV (default 4): SLOW_DIV/2 cycles high, then SLOW_DIV/2 cycles low. `aux_pass` is 1.
- R3: Code 01 with strobe-select 0 makes `card_clk` the crystal divided by FAST_DIV (default 2). `aux_pass` is 1.
- R4: Code 10 with strobe-select 0 makes `card_clk` toggle once per `osc_tick`. `aux_pass` is 0.
- R5: Code 11 with strobe-select 0 holds `card_clk` low. `aux_pass` is 1.
- R6: Strobe-select 1 makes `card_clk` equal `strobe_in` one cycle later, whatever the code. `aux_pass` is 1.
- R7: While `sleep_mode` is 1, `card_clk` does not rise and `aux_pass` is 0. After any high phase already in progress ends, `card_clk` stays low.
- R8: `use_strobe` and `div_code` are captured only in a cycle where `act_start` is 1. Changes to them at any other time leave the outputs unchanged.
- R9: A new source or ratio takes over only in a cycle where `card_clk` is low. A high phase in progress always completes at the old source's length. The new source then starts from a fresh low phase.
- R10: While `clk_en` is 0, `card_clk` does not rise. A high phase in progress completes normally. When `clk_en` returns, the divided sources restart from a fresh low phase.
- R11: `aux_div` toggles in the cycle after each `osc_tick` and is otherwise steady, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle tick at the internal oscillator rate |
| strobe_in | input | 1 | External strobe, already synchronous to clk |
| sleep_mode | input | 1 | 1 = sleep override |
| use_strobe | input | 1 | Source request: 1 = strobe |
| div_code | input | 2 | Divide request: 00 slow, 01 fast, 10 half-oscillator, 11 park low |
| act_start | input | 1 | Captures use_strobe and div_code |
| clk_en | input | 1 | Sequencer enable for the card clock |
| card_clk | output | 1 | Card clock level |
| aux_pass | output | 1 | 1 = auxiliary output passes the crystal clock |
| aux_div | output | 1 | Half-oscillator level for the auxiliary output |

## Verification
Every output is registered. Each result appears on the first clock edge after the inputs that cause it are sampled. The exceptions are a request captured by `act_start`, which shows one edge later, and a switch that meets a high phase, which waits until that phase has ended. A behavioural model in the bench updates at each rising edge from the same input values the design sees. The design's outputs are compared with the model at the following falling edge, so every pending switch and every partly finished high phase is checked in the exact cycle it resolves.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    typedef enum logic [2:0] {
        SRC_SLOW  = 3'd0,
        SRC_FAST  = 3'd1,
        SRC_OSC   = 3'd2,
        SRC_PARK  = 3'd3,
        SRC_STB   = 3'd4,
        SRC_SLEEP = 3'd5
    } src_e;

    typedef struct packed {
        logic       stb;
        logic [1:0] code;
    } sel_t;

    localparam sel_t SEL_RESET = '{stb: 1'b0, code: 2'b11};

    function automatic src_e pick_src(input logic sleep, input sel_t s);
        src_e r;
        if (sleep)        r = SRC_SLEEP;
        else if (s.stb)   r = SRC_STB;
        else begin
            case (s.code)
                2'b00:   r = SRC_SLOW;
                2'b01:   r = SRC_FAST;
                2'b10:   r = SRC_OSC;
                default: r = SRC_PARK;
            endcase
        end
        return r;
    endfunction

    function automatic logic aux_from_xtal(input src_e s);
        return !(s == SRC_OSC || s == SRC_SLEEP);
    endfunction

endpackage

// File: rtl/ccs_req_latch.sv
module ccs_req_latch
    import ccs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       act_start,
    input  logic       use_strobe,
    input  logic [1:0] div_code,
    output sel_t       req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= SEL_RESET;
        end else if (act_start) begin
            req.stb  <= use_strobe;
            req.code <= div_code;
        end
    end

endmodule

// File: rtl/ccs_card_gen.sv
module ccs_card_gen
    import ccs_pkg::*;
#(
    parameter int SLOW_DIV = 4,
    parameter int FAST_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  src_e want,
    input  logic osc_tick,
    input  logic strobe_in,
    input  logic clk_en,
    output logic card_clk,
    output src_e cur
);

    localparam int SLOW_HALF = SLOW_DIV / 2;
    localparam int FAST_HALF = FAST_DIV / 2;
    localparam int CW        = $clog2(SLOW_HALF + 1);

    logic [CW-1:0] cnt_q, cnt_n, cnt_gen;
    logic          card_q, card_n, gen_lvl;
    src_e          cur_q, cur_n;

    always_comb begin
        gen_lvl = 1'b0;
        cnt_gen = '0;
        case (cur_q)
            SRC_SLOW: begin
                if (cnt_q == CW'(SLOW_HALF - 1)) begin
                    gen_lvl = !card_q;
                    cnt_gen = '0;
                end else begin
                    gen_lvl = card_q;
                    cnt_gen = cnt_q + CW'(1);
                end
            end
            SRC_FAST: begin
                if (cnt_q == CW'(FAST_HALF - 1)) begin
                    gen_lvl = !card_q;
                    cnt_gen = '0;
                end else begin
                    gen_lvl = card_q;
                    cnt_gen = cnt_q + CW'(1);
                end
            end
            SRC_OSC:  gen_lvl = card_q ^ osc_tick;
            SRC_STB:  gen_lvl = strobe_in;
            default:  gen_lvl = 1'b0;
        endcase
    end

    always_comb begin
        cur_n  = cur_q;
        cnt_n  = cnt_gen;
        card_n = gen_lvl;
        if (want != cur_q && !card_q) begin
            cur_n  = want;
            cnt_n  = '0;
            card_n = 1'b0;
        end else if (!clk_en) begin
            if (!card_q) begin
                card_n = 1'b0;
                cnt_n  = '0;
            end else begin
                card_n = gen_lvl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= SRC_PARK;
            cnt_q  <= '0;
            card_q <= 1'b0;
        end else begin
            cur_q  <= cur_n;
            cnt_q  <= cnt_n;
            card_q <= card_n;
        end
    end

    assign card_clk = card_q;
    assign cur      = cur_q;

endmodule

// File: rtl/ccs_aux_gen.sv
module ccs_aux_gen
    import ccs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_e want,
    input  logic osc_tick,
    output logic aux_pass,
    output logic aux_div
);

    always_ff @(posedge clk) begin
        if (rst) begin
            aux_pass <= 1'b1;
            aux_div  <= 1'b0;
        end else begin
            aux_pass <= aux_from_xtal(want);
            if (osc_tick) aux_div <= !aux_div;
        end
    end

endmodule

// File: rtl/card_clk_sel.sv
module card_clk_sel
    import ccs_pkg::*;
#(
    parameter int SLOW_DIV = 4,
    parameter int FAST_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       strobe_in,
    input  logic       sleep_mode,
    input  logic       use_strobe,
    input  logic [1:0] div_code,
    input  logic       act_start,
    input  logic       clk_en,
    output logic       card_clk,
    output logic       aux_pass,
    output logic       aux_div
);

    sel_t req;
    src_e want;
    src_e cur;

    ccs_req_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .act_start  (act_start),
        .use_strobe (use_strobe),
        .div_code   (div_code),
        .req        (req)
    );

    assign want = pick_src(sleep_mode, req);

    ccs_card_gen #(
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_card (
        .clk       (clk),
        .rst       (rst),
        .want      (want),
        .osc_tick  (osc_tick),
        .strobe_in (strobe_in),
        .clk_en    (clk_en),
        .card_clk  (card_clk),
        .cur       (cur)
    );

    ccs_aux_gen u_aux (
        .clk      (clk),
        .rst      (rst),
        .want     (want),
        .osc_tick (osc_tick),
        .aux_pass (aux_pass),
        .aux_div  (aux_div)
    );

endmodule

// File: rtl/card_clk_sel_chk.sv
module card_clk_sel_chk (
    input logic clk,
    input logic rst,
    input logic osc_tick,
    input logic clk_en,
    input logic sleep_mode,
    input logic card_clk,
    input logic aux_pass,
    input logic aux_div
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!card_clk && !aux_div && aux_pass));

    // R7
    sleep_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep_mode && !card_clk) |=> !card_clk);

    // R7
    sleep_aux_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_mode |=> !aux_pass);

    // R10
    gate_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !card_clk) |=> !card_clk);

    // R11
    aux_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        osc_tick |=> (aux_div != $past(aux_div)));

    // R11
    aux_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_tick |=> $stable(aux_div));

endmodule

bind card_clk_sel card_clk_sel_chk u_chk (.*);

// File: tb/sim_card_clk_sel.sv
`timescale 1ns/1ps
module sim_card_clk_sel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       strobe_in = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       use_strobe = 1'b0;
    logic [1:0] div_code = 2'b11;
    logic       act_start = 1'b0;
    logic       clk_en = 1'b1;
    logic       card_clk, aux_pass, aux_div;

    int total = 0;
    int bad = 0;
    string tag = "R1";
    logic armed = 1'b0;
    int tick_gap = 5;
    int tick_cnt = 0;
    logic [7:0] lfsr = 8'h5a;

    always #5 clk = !clk;

    card_clk_sel u0 (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .strobe_in(strobe_in),
        .sleep_mode(sleep_mode), .use_strobe(use_strobe), .div_code(div_code),
        .act_start(act_start), .clk_en(clk_en), .card_clk(card_clk),
        .aux_pass(aux_pass), .aux_div(aux_div)
    );

    // behavioural reference: mode numbers 0 slow,1 fast,2 osc,3 park,4 strobe,5 sleep
    int   m_mode;
    int   m_phase;
    logic m_card, m_auxp, m_auxd, m_rs;
    logic [1:0] m_rc;
    int   target, half;
    logic nxt;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 3; m_phase = 0; m_card = 0; m_auxp = 1; m_auxd = 0;
            m_rs = 0; m_rc = 2'b11;
        end else begin
            if (sleep_mode)      target = 5;
            else if (m_rs)       target = 4;
            else                 target = int'(m_rc);
            m_auxp = !(target == 2 || target == 5);
            if (osc_tick) m_auxd = !m_auxd;
            if (target != m_mode && !m_card) begin
                m_mode = target; m_phase = 0; m_card = 0;
            end else begin
                nxt = 0;
                if (m_mode == 0 || m_mode == 1) begin
                    half = (m_mode == 0) ? 2 : 1;
                    m_phase = m_phase + 1;
                    if (m_phase >= half) begin nxt = !m_card; m_phase = 0; end
                    else nxt = m_card;
                end else if (m_mode == 2) nxt = m_card ^ osc_tick;
                else if (m_mode == 4)     nxt = strobe_in;
                if (!clk_en && !m_card) begin nxt = 0; m_phase = 0; end
                m_card = nxt;
            end
            if (act_start) begin m_rs = use_strobe; m_rc = div_code; end
        end
    end

    task automatic chk(input string what, input logic a, input logic e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, a, e, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (armed) begin
                chk("card_clk", card_clk, m_card);
                chk("aux_pass", aux_pass, m_auxp);
                chk("aux_div",  aux_div,  m_auxd);
            end
            tick_cnt++;
            osc_tick = (tick_cnt >= tick_gap);
            if (tick_cnt >= tick_gap) tick_cnt = 0;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            strobe_in = lfsr[0];
        end
    endtask

    task automatic activate(input logic s, input logic [1:0] c);
        use_strobe = s; div_code = c; act_start = 1'b1;
        step(1);
        act_start = 1'b0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        armed = 1'b1;
        tag = "R1"; step(3);
        rst = 1'b0;
        step(1);
        tag = "R5"; step(12);
        tag = "R2"; activate(1'b0, 2'b00); step(40);
        tag = "R3"; activate(1'b0, 2'b01); step(30);
        tag = "R4"; activate(1'b0, 2'b10); step(60);
        tag = "R5"; activate(1'b0, 2'b11); step(20);
        tag = "R6"; activate(1'b1, 2'b01); step(60);
        tag = "R8";
        for (int k = 0; k < 12; k++) begin
            use_strobe = k[0]; div_code = 2'(k); step(3);
        end
        activate(1'b0, 2'b00); step(6);
        div_code = 2'b01; use_strobe = 1'b1; step(30);
        tag = "R9";
        for (int k = 0; k < 16; k++) begin
            activate(1'b0, (k % 3 == 0) ? 2'b10 : 2'(k[0]));
            step(1 + (k % 5));
        end
        activate(1'b1, 2'b00); step(7);
        activate(1'b0, 2'b00); step(15);
        tag = "R10";
        for (int k = 0; k < 10; k++) begin
            clk_en = 1'b0; step(1 + (k % 4));
            clk_en = 1'b1; step(2 + (k % 3));
        end
        activate(1'b1, 2'b00);
        for (int k = 0; k < 6; k++) begin
            clk_en = 1'b0; step(5); clk_en = 1'b1; step(4);
        end
        tag = "R7";
        activate(1'b0, 2'b00); step(5);
        sleep_mode = 1'b1; step(40);
        sleep_mode = 1'b0; step(20);
        activate(1'b1, 2'b00); step(3);
        sleep_mode = 1'b1; step(20);
        sleep_mode = 1'b0; step(10);
        tag = "R11";
        tick_gap = 3; activate(1'b0, 2'b10); step(40);
        tick_gap = 1; step(20);
        sleep_mode = 1'b1; tick_gap = 7; step(40);
        sleep_mode = 1'b0; activate(1'b0, 2'b01); step(20);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule